// File: doc/BRIEF.md
# Compact UART with Automatic Flow Control

This block is a small serial port for a register-mapped peripheral bus. A transmitter and a receiver each sit behind their own eight-entry FIFO. One shared tick generator, set by a 16-bit divisor, paces both sides at eight ticks per serial bit. Characters are 7 or 8 data bits with a single stop bit and no parity.

Software writes characters into the transmit FIFO and reads received characters out of the receive FIFO through one data word. Flow control can run without software: the request-to-send output can be dropped once the receive FIFO gets close to full, and the transmitter can be made to wait while clear-to-send is inactive. The polarity of each line can be inverted. An interrupt identification word and a packed status word, which includes both FIFO fill levels, give software what it needs to run the port.

The bus is word indexed. Index 0 is the data word, 1 is the interrupt enables, 2 is interrupt identification on read and FIFO flush on write, 3 is line control, 4 is port control, 5 is status and 6 is the divisor. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational, and a read of index 0 pops the receive FIFO on that edge. After reset both directions are enabled, the port runs in 8-bit mode, the divisor is 0 and all interrupt enables are clear.

Top module: `lite_uart`

## Requirements
- R1: Each serial bit, the start bit included, lasts exactly 8 × (divisor + 1) clock cycles. The divisor is bits [15:0] of word 6.
- R2: In 8-bit mode a frame is one low start bit, then eight data bits least significant bit first, then one high stop bit. A byte written to word 0 and looped back from `txd` to `rxd` reads back unchanged from word 0.
- R3: Line control word 3, bits [1:0], selects the character size: value 3 gives 8 bits and value 2 gives 7 bits. In 7-bit mode only the seven low bits are sent, seven bits are received, and bit 7 of a received character reads 0.
- R4: While line control bit 6 is set, `txd` is low from the cycle after the write, whatever the transmit FIFO holds.
- R5: Word 2 reads 3'b001 when nothing is pending. It reads 3'b100 for a receive interrupt (enable bit 0 of word 1 set and receive FIFO not empty). It reads 3'b010 for a transmit interrupt (enable bit 1 set and transmit FIFO empty). Receive takes priority over transmit. `irq` is high exactly when bit 0 of word 2 is 0.
- R6: With automatic RTS (word 4 bit 2) set, `rts_o` is deasserted once the receive FIFO has N or fewer free entries. Field word 4 [5:4] gives N: 0→3, 1→2, 2→1, 3→4. Asserted means high; word 4 bit 6 inverts this. With automatic RTS off, `rts_o` stays high.
- R7: With automatic CTS (word 4 bit 3) set, no new character starts while the synchronized `cts_i` is inactive. Inactive means low, or high when word 4 bit 7 is set. A waiting character goes out once CTS becomes active.
- R8: The status word (word 5) holds: bit 0 receive data present, bit 1 transmit space, bit 2 receiver idle, bit 3 transmitter idle, bit 4 overrun, bit 5 transmit FIFO full, bit 6 `rts_o` level, bit 7 synchronized `cts_i`, bit 8 transmit FIFO empty, bit 9 transmit FIFO empty and transmitter idle, [23:16] receive fill, [31:24] transmit fill.
- R9: Word 4 bit 0 enables the receiver and bit 1 enables the transmitter. A disabled receiver ignores incoming frames, and a disabled transmitter leaves its characters in the FIFO.
- R10: Writing word 2 with bit 1 set empties the receive FIFO. Writing it with bit 2 set empties the transmit FIFO.
- R11: Both FIFOs hold 8 entries. A character that completes while the receive FIFO is full is dropped and sets status bit 4. The bit stays set until status is read, and it reads 0 after that.
- R12: A falling edge on `rxd` whose line is high again at the fourth tick is discarded: nothing is received and the receiver returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data at word 0) |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the index |
| irq | output | 1 | Interrupt request |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rts_o | output | 1 | Request-to-send output |
| cts_i | input | 1 | Clear-to-send input |

## Verification
The hardest state to reach from the ports is a receive FIFO at or near its limit, because it takes several complete serial frames driven at the exact bit period. That is the state where the RTS thresholds and the overrun drop both act. The bench drives frames bit by bit on `rxd` with loopback switched off, counting clocks from the divisor. It checks `rts_o` after each frame, pushes a ninth frame into a full FIFO, then drains the FIFO to prove the dropped character never arrived. The CTS stall is reached by holding `cts_i` inactive with a character queued and watching `txd` stay high for many bit times.

// File: rtl/lite_uart_pkg.sv
package lite_uart_pkg;

   typedef enum logic [1:0] {
      LN_IDLE,
      LN_START,
      LN_DATA,
      LN_STOP
   } line_st_e;

   // status word bit positions
   localparam int unsigned SB_RX_AVAIL = 0;
   localparam int unsigned SB_TX_SPACE = 1;
   localparam int unsigned SB_RX_IDLE  = 2;
   localparam int unsigned SB_TX_IDLE  = 3;
   localparam int unsigned SB_OVERRUN  = 4;
   localparam int unsigned SB_TX_FULL  = 5;
   localparam int unsigned SB_RTS      = 6;
   localparam int unsigned SB_CTS      = 7;
   localparam int unsigned SB_TX_EMPTY = 8;
   localparam int unsigned SB_DONE     = 9;

   // word indices
   localparam logic [2:0] W_DATA = 3'd0;
   localparam logic [2:0] W_IEN  = 3'd1;
   localparam logic [2:0] W_IID  = 3'd2;
   localparam logic [2:0] W_LINE = 3'd3;
   localparam logic [2:0] W_CTRL = 3'd4;
   localparam logic [2:0] W_STAT = 3'd5;
   localparam logic [2:0] W_DIV  = 3'd6;

   // free-entry count at which automatic RTS drops
   function automatic logic [7:0] rts_free_limit(input logic [1:0] code);
      case (code)
         2'd0:    rts_free_limit = 8'd3;
         2'd1:    rts_free_limit = 8'd2;
         2'd2:    rts_free_limit = 8'd1;
         default: rts_free_limit = 8'd4;
      endcase
   endfunction

endpackage

// File: rtl/lite_uart_fifo.sv
module lite_uart_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             empty
);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic             do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/lite_uart_sync.sv
module lite_uart_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/lite_uart_tx.sv
module lite_uart_tx
   import lite_uart_pkg::*;
#(
   parameter int unsigned OSR = 8,
   localparam int unsigned SW = $clog2(OSR)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       enable,
   input  logic       seven,
   input  logic       cts_ok,
   input  logic       brk,
   input  logic       have_data,
   input  logic [7:0] din,
   output logic       pop,
   output logic       txd,
   output logic       idle
);

   localparam logic [SW-1:0] SUB_LAST = SW'(OSR - 1);

   line_st_e   st;
   logic [SW-1:0] sub;
   logic [2:0] idx;
   logic [7:0] sh;
   logic       line_lvl;
   logic [2:0] last_idx;

   assign last_idx = seven ? 3'd6 : 3'd7;
   assign idle     = (st == LN_IDLE);
   assign pop      = idle && tick && enable && have_data && cts_ok;

   always_comb begin
      case (st)
         LN_START: line_lvl = 1'b0;
         LN_DATA:  line_lvl = sh[0];
         default:  line_lvl = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= LN_IDLE;
         sub <= '0;
         idx <= '0;
         sh  <= '0;
         txd <= 1'b1;
      end else begin
         txd <= brk ? 1'b0 : line_lvl;
         case (st)
            LN_IDLE: begin
               if (pop) begin
                  sh  <= din;
                  sub <= '0;
                  st  <= LN_START;
               end
            end
            LN_START: begin
               if (tick) begin
                  if (sub == SUB_LAST) begin
                     sub <= '0;
                     idx <= '0;
                     st  <= LN_DATA;
                  end else begin
                     sub <= sub + 1'b1;
                  end
               end
            end
            LN_DATA: begin
               if (tick) begin
                  if (sub == SUB_LAST) begin
                     sub <= '0;
                     sh  <= {1'b1, sh[7:1]};
                     if (idx == last_idx) st <= LN_STOP;
                     else                 idx <= idx + 1'b1;
                  end else begin
                     sub <= sub + 1'b1;
                  end
               end
            end
            default: begin
               if (tick) begin
                  if (sub == SUB_LAST) begin
                     sub <= '0;
                     st  <= LN_IDLE;
                  end else begin
                     sub <= sub + 1'b1;
                  end
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/lite_uart_rx.sv
module lite_uart_rx
   import lite_uart_pkg::*;
#(
   parameter int unsigned OSR = 8,
   localparam int unsigned SW = $clog2(OSR)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       enable,
   input  logic       seven,
   input  logic       rxd_s,
   output logic       push,
   output logic [7:0] dout,
   output logic       idle
);

   localparam logic [SW-1:0] SUB_MID = SW'(OSR / 2 - 1);

   line_st_e   st;
   logic [SW-1:0] sub;
   logic [2:0] idx;
   logic [7:0] sh;
   logic       prev;
   logic       mid;
   logic [2:0] last_idx;

   assign last_idx = seven ? 3'd6 : 3'd7;
   assign idle     = (st == LN_IDLE);
   assign mid      = tick && (sub == SUB_MID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= LN_IDLE;
         sub  <= '0;
         idx  <= '0;
         sh   <= '0;
         prev <= 1'b1;
         push <= 1'b0;
         dout <= '0;
      end else begin
         prev <= rxd_s;
         push <= 1'b0;
         if (st != LN_IDLE && tick) sub <= sub + 1'b1;
         case (st)
            LN_IDLE: begin
               if (enable && prev && !rxd_s) begin
                  sub <= '0;
                  st  <= LN_START;
               end
            end
            LN_START: begin
               if (mid) begin
                  if (rxd_s) begin
                     st <= LN_IDLE;
                  end else begin
                     idx <= '0;
                     st  <= LN_DATA;
                  end
               end
            end
            LN_DATA: begin
               if (mid) begin
                  sh <= {rxd_s, sh[7:1]};
                  if (idx == last_idx) st <= LN_STOP;
                  else                 idx <= idx + 1'b1;
               end
            end
            default: begin
               if (mid) begin
                  push <= 1'b1;
                  dout <= seven ? {1'b0, sh[7:1]} : sh;
                  st   <= LN_IDLE;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/lite_uart.sv
module lite_uart
   import lite_uart_pkg::*;
#(
   parameter int unsigned DEPTH       = 8,
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned OSR         = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned CNT_W      = $clog2(DEPTH) + 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [2:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq,
   output logic        txd,
   input  logic        rxd,
   output logic        rts_o,
   input  logic        cts_i
);

   generate
      if (DEPTH < 2 || DEPTH > 128 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two from 2 to 128");
      end
      if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
         $error("OSR must be a power of two of at least 4");
      end
      if (DIV_W < 1 || DIV_W > 32) begin : g_bad_div
         $error("DIV_W must lie in 1..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   // control state
   logic             ien_rx_q, ien_tx_q;
   logic             eight_q, brk_q;
   logic             rx_en_q, tx_en_q, auto_rts_q, auto_cts_q, rts_inv_q, cts_inv_q;
   logic [1:0]       rts_code_q;
   logic [DIV_W-1:0] div_q, baud_cnt;
   logic             ovf_q, rts_q;

   logic wr_data, wr_ien, wr_iid, wr_line, wr_ctrl, wr_div, rd_data, rd_stat;
   assign wr_data = bus_wr && bus_addr == W_DATA;
   assign wr_ien  = bus_wr && bus_addr == W_IEN;
   assign wr_iid  = bus_wr && bus_addr == W_IID;
   assign wr_line = bus_wr && bus_addr == W_LINE;
   assign wr_ctrl = bus_wr && bus_addr == W_CTRL;
   assign wr_div  = bus_wr && bus_addr == W_DIV;
   assign rd_data = bus_rd && bus_addr == W_DATA;
   assign rd_stat = bus_rd && bus_addr == W_STAT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_rx_q   <= 1'b0;
         ien_tx_q   <= 1'b0;
         eight_q    <= 1'b1;
         brk_q      <= 1'b0;
         rx_en_q    <= 1'b1;
         tx_en_q    <= 1'b1;
         auto_rts_q <= 1'b0;
         auto_cts_q <= 1'b0;
         rts_code_q <= 2'd0;
         rts_inv_q  <= 1'b0;
         cts_inv_q  <= 1'b0;
         div_q      <= '0;
      end else begin
         if (wr_ien) begin
            ien_rx_q <= bus_wdata[0];
            ien_tx_q <= bus_wdata[1];
         end
         if (wr_line) begin
            eight_q <= bus_wdata[0];
            brk_q   <= bus_wdata[6];
         end
         if (wr_ctrl) begin
            rx_en_q    <= bus_wdata[0];
            tx_en_q    <= bus_wdata[1];
            auto_rts_q <= bus_wdata[2];
            auto_cts_q <= bus_wdata[3];
            rts_code_q <= bus_wdata[5:4];
            rts_inv_q  <= bus_wdata[6];
            cts_inv_q  <= bus_wdata[7];
         end
         if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
      end
   end

   // oversample tick
   logic tick;
   assign tick = (baud_cnt >= div_q);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    baud_cnt <= '0;
      else if (tick) baud_cnt <= '0;
      else           baud_cnt <= baud_cnt + 1'b1;
   end

   // input synchronizers
   logic cts_s, rxd_s;
   lite_uart_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cts_sync (
      .clk(clk), .rst_n(rst_n), .d(cts_i), .q(cts_s));
   lite_uart_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxd_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s));

   // FIFOs
   logic             tx_pop, tx_full, tx_empty, rx_push, rx_full, rx_empty;
   logic [7:0]       tx_head, rx_head, rx_char;
   logic [CNT_W-1:0] tx_count, rx_count;

   lite_uart_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n), .flush(wr_iid && bus_wdata[2]),
      .push(wr_data), .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_head),
      .count(tx_count), .full(tx_full), .empty(tx_empty));

   lite_uart_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n), .flush(wr_iid && bus_wdata[1]),
      .push(rx_push), .din(rx_char), .pop(rd_data), .dout(rx_head),
      .count(rx_count), .full(rx_full), .empty(rx_empty));

   // flow control
   logic       cts_ok;
   logic [7:0] rx_count8, rx_free, rts_limit;
   logic       rts_want;
   assign cts_ok    = !auto_cts_q || (cts_s ^ cts_inv_q);
   assign rx_count8 = 8'(rx_count);
   assign rx_free   = 8'(DEPTH) - rx_count8;
   assign rts_limit = rts_free_limit(rts_code_q);
   assign rts_want  = !auto_rts_q || (rx_free > rts_limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rts_q <= 1'b1;
      else        rts_q <= rts_want ^ (auto_rts_q && rts_inv_q);
   end
   assign rts_o = rts_q;

   // serial engines
   logic tx_idle, rx_idle;
   lite_uart_tx #(.OSR(OSR)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .enable(tx_en_q), .seven(!eight_q),
      .cts_ok(cts_ok), .brk(brk_q), .have_data(!tx_empty), .din(tx_head),
      .pop(tx_pop), .txd(txd), .idle(tx_idle));

   lite_uart_rx #(.OSR(OSR)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .enable(rx_en_q), .seven(!eight_q),
      .rxd_s(rxd_s), .push(rx_push), .dout(rx_char), .idle(rx_idle));

   // overrun flag: a new drop wins over a clearing read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ovf_q <= 1'b0;
      else if (rx_push && rx_full) ovf_q <= 1'b1;
      else if (rd_stat)            ovf_q <= 1'b0;
   end

   // interrupts
   logic       rx_pend, tx_pend;
   logic [2:0] iid;
   assign rx_pend = ien_rx_q && !rx_empty;
   assign tx_pend = ien_tx_q && tx_empty;
   always_comb begin
      if (rx_pend)      iid = 3'b100;
      else if (tx_pend) iid = 3'b010;
      else              iid = 3'b001;
   end
   assign irq = rx_pend || tx_pend;

   // status word
   logic [31:0] stat;
   always_comb begin
      stat              = '0;
      stat[SB_RX_AVAIL] = !rx_empty;
      stat[SB_TX_SPACE] = !tx_full;
      stat[SB_RX_IDLE]  = rx_idle;
      stat[SB_TX_IDLE]  = tx_idle;
      stat[SB_OVERRUN]  = ovf_q;
      stat[SB_TX_FULL]  = tx_full;
      stat[SB_RTS]      = rts_q;
      stat[SB_CTS]      = cts_s;
      stat[SB_TX_EMPTY] = tx_empty;
      stat[SB_DONE]     = tx_empty && tx_idle;
      stat[23:16]       = rx_count8;
      stat[31:24]       = 8'(tx_count);
   end

   always_comb begin
      case (bus_addr)
         W_DATA:  bus_rdata = {24'd0, rx_head};
         W_IEN:   bus_rdata = {30'd0, ien_tx_q, ien_rx_q};
         W_IID:   bus_rdata = {29'd0, iid};
         W_LINE:  bus_rdata = {24'd0, brk_q, 5'd0, 1'b1, eight_q};
         W_CTRL:  bus_rdata = {24'd0, cts_inv_q, rts_inv_q, rts_code_q,
                               auto_cts_q, auto_rts_q, tx_en_q, rx_en_q};
         W_STAT:  bus_rdata = stat;
         W_DIV:   bus_rdata = 32'(div_q);
         default: bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/lite_uart_chk.sv
module lite_uart_chk #(
   parameter int unsigned DEPTH = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       brk,
   input logic       txd,
   input logic       irq,
   input logic [2:0] iid,
   input logic       tx_idle,
   input logic       auto_cts,
   input logic       cts_ok,
   input logic       auto_rts,
   input logic       rts_inv,
   input logic [7:0] rx_free,
   input logic [7:0] rts_limit,
   input logic       rts_o,
   input logic [7:0] rx_count,
   input logic       rx_push,
   input logic       rx_full,
   input logic       ovf
);

   assert_break_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      brk |=> !txd);

   assert_iid_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(iid) == 1);

   assert_irq_vs_iid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq == !iid[0]);

   assert_rts_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_rts && rx_free <= rts_limit) |=> (rts_o == $past(rts_inv)));

   assert_cts_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_idle && auto_cts && !cts_ok) |=> tx_idle);

   assert_rx_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= 8'(DEPTH));

   assert_overrun_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_full) |=> ovf);

endmodule

bind lite_uart lite_uart_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .brk(brk_q), .txd(txd), .irq(irq), .iid(iid),
   .tx_idle(tx_idle), .auto_cts(auto_cts_q), .cts_ok(cts_ok),
   .auto_rts(auto_rts_q), .rts_inv(rts_inv_q), .rx_free(rx_free),
   .rts_limit(rts_limit), .rts_o(rts_o), .rx_count(rx_count8),
   .rx_push(rx_push), .rx_full(rx_full), .ovf(ovf_q));

// File: tb/sim_lite_uart.sv
module sim_lite_uart;

   localparam int unsigned CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, txd, rts_o;
   logic        cts_i = 1'b1;
   logic        loop = 1'b0;
   logic        drv_rxd = 1'b1;
   logic        rxd;
   int          n_tests = 0, n_fail = 0;
   bit          done = 1'b0;
   int unsigned cur_div = 0;

   assign rxd = loop ? txd : drv_rxd;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lite_uart u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .txd(txd), .rxd(rxd), .rts_o(rts_o), .cts_i(cts_i));

   // expected-value helpers
   function automatic int unsigned bit_clocks(input int unsigned d);
      return 8 * (d + 1);
   endfunction
   function automatic logic [7:0] exp_char(input logic [7:0] b, input bit seven);
      return seven ? (b & 8'h7F) : b;
   endfunction
   function automatic logic [2:0] exp_iid(input bit rxp, input bit txp);
      return rxp ? 3'b100 : (txp ? 3'b010 : 3'b001);
   endfunction
   function automatic bit exp_rts(input int free, input int code, input bit inv);
      int lim;
      lim = (code == 0) ? 3 : (code == 1) ? 2 : (code == 2) ? 1 : 4;
      return (free > lim) ? !inv : inv;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic set_div(input int unsigned d);
      cur_div = d;
      wr(3'd6, d);
   endtask

   task automatic send_frame(input logic [7:0] b, input int nbits);
      int unsigned n;
      n = bit_clocks(cur_div);
      @(negedge clk); drv_rxd = 1'b0;
      repeat (n) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         drv_rxd = b[i];
         repeat (n) @(negedge clk);
      end
      drv_rxd = 1'b1;
      repeat (n + 4) @(negedge clk);
   endtask

   task automatic wait_rx(output bit got);
      logic [31:0] s;
      got = 1'b0;
      for (int i = 0; i < 600 && !got; i++) begin
         rd(3'd5, s);
         got = s[0];
      end
   endtask

   task automatic loop_byte(input logic [7:0] b, input bit seven, input string tag);
      logic [31:0] d;
      bit got;
      wr(3'd0, {24'd0, b});
      wait_rx(got);
      check({tag, " rx arrived"}, {31'd0, got}, 32'd1);
      rd(3'd0, d);
      check(tag, d, {24'd0, exp_char(b, seven)});
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int cnt;
      bit hi;
      logic [7:0] bytes [9];
      void'($urandom(32'd20240611));

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R8 reset status
      rd(3'd5, d);
      check("R8 reset status", d, 32'h0000_03CE);
      rd(3'd2, d);
      check("R5 reset iid", d, 32'd1);
      check("R6 rts after reset", {31'd0, rts_o}, 32'd1);

      // R1 bit timing at two divisors
      loop = 1'b1;
      for (int k = 0; k < 2; k++) begin
         set_div(k == 0 ? 2 : 0);
         wr(3'd0, 32'h55);
         cnt = 0;
         while (txd) @(negedge clk);
         while (!txd) begin cnt++; @(negedge clk); end
         check("R1 start bit length", cnt, bit_clocks(cur_div));
         repeat (12 * bit_clocks(cur_div)) @(negedge clk);
         rd(3'd0, d);
         check("R2 timing byte", d, 32'h55);
      end

      // R2 random loopback, random divisors
      for (int k = 0; k < 10; k++) begin
         set_div(1 + ($urandom % 3));
         loop_byte(8'($urandom), 1'b0, "R2 loopback");
      end

      // R3 seven-bit mode
      set_div(1);
      wr(3'd3, 32'h02);
      loop_byte(8'hD3, 1'b1, "R3 seven-bit loopback");
      loop = 1'b0;
      send_frame(8'h2A, 7);
      rd(3'd0, d);
      check("R3 seven-bit serial in", d, 32'h2A);
      wr(3'd3, 32'h03);

      // R4 break
      wr(3'd3, 32'h43);
      @(negedge clk);
      check("R4 break low", {31'd0, txd}, 32'd0);
      wr(3'd0, 32'hFF);
      hi = 1'b0;
      repeat (200) begin @(negedge clk); if (txd) hi = 1'b1; end
      check("R4 break holds", {31'd0, hi}, 32'd0);
      wr(3'd3, 32'h03);
      repeat (200) @(negedge clk);
      check("R4 break released", {31'd0, txd}, 32'd1);
      wr(3'd2, 32'h02);

      // R5 interrupts
      wr(3'd1, 32'h2);
      rd(3'd2, d);
      check("R5 tx iid", d, {29'd0, exp_iid(0, 1)});
      check("R5 tx irq", {31'd0, irq}, 32'd1);
      wr(3'd1, 32'h3);
      send_frame(8'h81, 8);
      rd(3'd2, d);
      check("R5 rx priority", d, {29'd0, exp_iid(1, 1)});
      rd(3'd0, d);
      check("R5 rx data", d, 32'h81);
      wr(3'd1, 32'h0);
      rd(3'd2, d);
      check("R5 none pending", d, {29'd0, exp_iid(0, 0)});
      check("R5 irq low", {31'd0, irq}, 32'd0);

      // R6 automatic RTS, code 0 then code 3, then inverted
      wr(3'd4, 32'h07);
      for (int k = 1; k <= 5; k++) begin
         send_frame(8'(k), 8);
         check($sformatf("R6 rts code0 after %0d", k), {31'd0, rts_o},
               {31'd0, exp_rts(8 - k, 0, 0)});
      end
      wr(3'd2, 32'h02);
      wr(3'd4, 32'h37);
      for (int k = 1; k <= 4; k++) begin
         send_frame(8'(k), 8);
         check($sformatf("R6 rts code3 after %0d", k), {31'd0, rts_o},
               {31'd0, exp_rts(8 - k, 3, 0)});
      end
      wr(3'd4, 32'h77);
      repeat (2) @(negedge clk);
      check("R6 inverted deasserted", {31'd0, rts_o}, {31'd0, exp_rts(4, 3, 1)});
      wr(3'd2, 32'h02);
      repeat (2) @(negedge clk);
      check("R6 inverted asserted", {31'd0, rts_o}, {31'd0, exp_rts(8, 3, 1)});
      rd(3'd5, d);
      check("R8 rts bit in status", {31'd0, d[6]}, {31'd0, rts_o});

      // R7 automatic CTS
      loop = 1'b1;
      cts_i = 1'b0;
      wr(3'd4, 32'h0B);
      wr(3'd0, 32'hA5);
      hi = 1'b1;
      repeat (400) begin @(negedge clk); if (!txd) hi = 1'b0; end
      check("R7 stalled line high", {31'd0, hi}, 32'd1);
      rd(3'd5, d);
      check("R7 tx fill while stalled", {24'd0, d[31:24]}, 32'd1);
      check("R8 cts bit", {31'd0, d[7]}, 32'd0);
      cts_i = 1'b1;
      wait_rx(hi);
      rd(3'd0, d);
      check("R7 sent after cts", d, 32'hA5);
      wr(3'd4, 32'h8B);
      wr(3'd0, 32'h3C);
      repeat (400) @(negedge clk);
      rd(3'd5, d);
      check("R7 inverted stall", {24'd0, d[31:24]}, 32'd1);
      cts_i = 1'b0;
      wait_rx(hi);
      rd(3'd0, d);
      check("R7 inverted sent", d, 32'h3C);
      cts_i = 1'b1;
      wr(3'd4, 32'h03);
      loop = 1'b0;

      // R9 receiver disabled
      wr(3'd4, 32'h02);
      send_frame(8'h66, 8);
      rd(3'd5, d);
      check("R9 rx disabled fill", {24'd0, d[23:16]}, 32'd0);

      // R9 tx disabled, R8 full flags, R10 flush
      wr(3'd4, 32'h01);
      for (int k = 0; k < 8; k++) wr(3'd0, 32'(k));
      repeat (300) @(negedge clk);
      rd(3'd5, d);
      check("R9 tx disabled holds", {24'd0, d[31:24]}, 32'd8);
      check("R8 tx full bits", {30'd0, d[5], d[1]}, 32'b10);
      wr(3'd2, 32'h04);
      rd(3'd5, d);
      check("R10 tx flush", {24'd0, d[31:24]}, 32'd0);
      wr(3'd4, 32'h03);

      // R11 overrun
      for (int k = 0; k < 9; k++) begin
         bytes[k] = 8'($urandom);
         send_frame(bytes[k], 8);
      end
      rd(3'd5, d);
      check("R11 overrun set", {31'd0, d[4]}, 32'd1);
      check("R11 fill at depth", {24'd0, d[23:16]}, 32'd8);
      rd(3'd5, d);
      check("R11 overrun cleared", {31'd0, d[4]}, 32'd0);
      for (int k = 0; k < 8; k++) begin
         rd(3'd0, d);
         check($sformatf("R11 drain %0d", k), d, {24'd0, bytes[k]});
      end
      send_frame(8'h11, 8);
      wr(3'd2, 32'h02);
      rd(3'd5, d);
      check("R10 rx flush", {24'd0, d[23:16]}, 32'd0);

      // R12 short glitch
      @(negedge clk); drv_rxd = 1'b0;
      repeat (2) @(negedge clk);
      drv_rxd = 1'b1;
      repeat (300) @(negedge clk);
      rd(3'd5, d);
      check("R12 glitch no data", {24'd0, d[23:16]}, 32'd0);
      check("R12 receiver idle", {31'd0, d[2]}, 32'd1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule